// File: doc/BRIEF.md
# QoS-Priority Address Arbiter

This block merges the address-channel requests of several managers onto one shared downstream address channel. Each upstream port offers a VALID/READY handshake with an address, a transaction ID and a 4-bit QoS priority. QoS travels with the address and has no handshake of its own. The arbiter gives the downstream channel to the valid port with the highest QoS. A value of zero means "no preference" and ranks lowest. When several ports share the top value, the winner rotates round-robin, starting at the port after the last one granted.

Once a port appears on the output, the arbiter keeps it there until the downstream handshake completes. A request that arrives later with a higher priority does not displace it. The request is forwarded without change, and the index of the granted port is driven alongside it so that responses can be routed back. Read and write address paths each use their own instance.

The arbiter has no output register. The selection is combinational from the port inputs, and only the lock and rotation state is registered. Each port is served in its own arrival order, so requests from one manager, including same-ID requests, are never reordered.

Top module: `qos_addr_arbiter`

## Requirements
- R1: After reset no grant is held and the rotation pointer sits at the last port, so with every port valid at equal QoS the first winner is port 0.
- R2: When not holding a grant, the output carries the valid port whose QoS is numerically largest.
- R3: QoS 0 carries no preference: a port at QoS 0 wins only when no valid port has a non-zero QoS.
- R4: Among valid ports that share the largest QoS, the winner is the first one found scanning upward from the port after the last granted one, wrapping from the highest index to 0.
- R5: While out_valid is high and out_ready is low, the granted port index and payload stay unchanged in the next cycle, even if a higher-QoS request appears.
- R6: req_ready has at most one bit set. Bit i is high only when port i is granted, out_valid is high and out_ready is high.
- R7: out_addr, out_id and out_qos equal the granted port's inputs, and out_port carries that port's index (bit i of req_valid is port i; port i's fields occupy slice [i*W +: W] of each flat bus).
- R8: With no port valid, out_valid and every req_ready bit are low.
- R9: A reset while a grant is held drops the grant and returns the rotation pointer to its reset position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_PORTS | Per-port request valid |
| req_ready | output | NUM_PORTS | Per-port request accepted |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port address, flat |
| req_id | input | NUM_PORTS*ID_W | Per-port transaction ID, flat |
| req_qos | input | NUM_PORTS*QOS_W | Per-port QoS priority, flat |
| out_valid | output | 1 | Downstream request valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | ADDR_W | Forwarded address |
| out_id | output | ID_W | Forwarded ID |
| out_qos | output | QOS_W | Forwarded QoS |
| out_port | output | IDX_W | Index of the granted port |

## Verification
The hardest situation to reach is a held grant being challenged. The downstream side stalls with a low-priority port on the output, and then a port with a higher QoS raises its request. The stimulus builds this in steps: it presents one low-QoS request with out_ready low, adds the higher-QoS request on the next cycle, checks that nothing has moved, and only then releases out_ready. After the release it checks that the challenger wins the following cycle. Rotation wrap-around is reached by a table of back-to-back handshakes. The table walks the pointer through every port, including the step from the highest index back to 0.

// File: rtl/qos_arb_pkg.sv
// Package: shared constants for the QoS address arbiter.
// Assumes: QoS field width is fixed at four bits across the project.
package qos_arb_pkg;
    localparam int          QOS_BITS = 4;
    localparam logic [3:0]  QOS_NONE = 4'b0000;

    // Index of the port after 'cur' in a ring of 'n' ports.
    function automatic int ring_next(input int cur, input int step, input int n);
        return (cur + step) % n;
    endfunction
endpackage

// File: rtl/qos_level_scan.sv
// Module: finds the largest QoS among valid ports and marks every valid
// port that carries it as a candidate.
// Assumes: QoS is unsigned; QOS_NONE (zero) ranks lowest.
module qos_level_scan #(
    parameter int NUM_PORTS = 4,
    parameter int QOS_W     = 4
) (
    input  logic [NUM_PORTS-1:0]       valid,
    input  logic [NUM_PORTS*QOS_W-1:0] qos,
    output logic [QOS_W-1:0]           top_qos,
    output logic [NUM_PORTS-1:0]       cand,
    output logic                       any_valid
);
    // Reduce to the largest QoS held by a valid port.
    always_comb begin
        top_qos   = '0;
        any_valid = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (valid[i]) begin
                any_valid = 1'b1;
                if (qos[i*QOS_W +: QOS_W] > top_qos)
                    top_qos = qos[i*QOS_W +: QOS_W];
            end
        end
    end

    // Mark valid ports that match the largest level.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++)
            cand[i] = valid[i] && (qos[i*QOS_W +: QOS_W] == top_qos);
    end
endmodule

// File: rtl/rr_select.sv
// Module: round-robin choice among candidate ports, scanning upward from
// the port after last_idx and wrapping.
// Assumes: last_idx is below NUM_PORTS; purely combinational.
module rr_select #(
    parameter int NUM_PORTS = 4,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [NUM_PORTS-1:0] cand,
    input  logic [IDX_W-1:0]     last_idx,
    output logic [IDX_W-1:0]     pick_idx,
    output logic                 pick_ok
);
    import qos_arb_pkg::*;

    // First candidate after last_idx in ring order.
    always_comb begin
        pick_idx = '0;
        pick_ok  = 1'b0;
        for (int k = 1; k <= NUM_PORTS; k++) begin
            int idx;
            idx = ring_next(int'(last_idx), k, NUM_PORTS);
            if (!pick_ok && cand[idx]) begin
                pick_idx = IDX_W'(idx);
                pick_ok  = 1'b1;
            end
        end
    end

    // The chosen port must be one of the candidates.
    always_comb begin
        if (pick_ok) begin
            AST_PICK_IS_CAND: assert (cand[pick_idx]); // R4
        end
    end
endmodule

// File: rtl/grant_keeper.sv
// Module: holds the grant across a stalled handshake and remembers the
// last granted port for rotation.
// Assumes: synchronous active-low reset; sel is the port on the output.
module grant_keeper #(
    parameter int NUM_PORTS = 4,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_valid,
    input  logic             out_ready,
    input  logic [IDX_W-1:0] sel,
    output logic             locked,
    output logic [IDX_W-1:0] lock_idx,
    output logic [IDX_W-1:0] last_idx
);
    localparam logic [IDX_W-1:0] LAST_RESET = IDX_W'(NUM_PORTS - 1);

    // Lock on a stalled offer, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            lock_idx <= '0;
        end else if (out_valid && out_ready) begin
            locked   <= 1'b0;
        end else if (out_valid && !locked) begin
            locked   <= 1'b1;
            lock_idx <= sel;
        end
    end

    // Move the rotation pointer on each completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_idx <= LAST_RESET;
        else if (out_valid && out_ready)
            last_idx <= sel;
    end

    AST_LOCK_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> locked); // R5
    AST_FREE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !locked); // R5
endmodule

// File: rtl/qos_addr_arbiter.sv
// Module: QoS-priority arbiter for one address channel. Picks the valid
// port with the largest QoS, breaks ties round-robin, holds the grant
// until the downstream handshake, forwards the request unchanged.
// Assumes: upstream sources keep VALID and payload stable until accepted;
// synchronous active-low reset.
module qos_addr_arbiter #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 4,
    parameter int QOS_W     = qos_arb_pkg::QOS_BITS,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    output logic [NUM_PORTS-1:0]        req_ready,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*ID_W-1:0]   req_id,
    input  logic [NUM_PORTS*QOS_W-1:0]  req_qos,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [ID_W-1:0]             out_id,
    output logic [QOS_W-1:0]            out_qos,
    output logic [IDX_W-1:0]            out_port
);
    logic [QOS_W-1:0]     top_qos;
    logic [NUM_PORTS-1:0] cand;
    logic                 any_valid;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_ok;
    logic                 locked;
    logic [IDX_W-1:0]     lock_idx;
    logic [IDX_W-1:0]     last_idx;
    logic [IDX_W-1:0]     sel;

    qos_level_scan #(.NUM_PORTS(NUM_PORTS), .QOS_W(QOS_W)) u_scan (
        .valid     (req_valid),
        .qos       (req_qos),
        .top_qos   (top_qos),
        .cand      (cand),
        .any_valid (any_valid)
    );

    rr_select #(.NUM_PORTS(NUM_PORTS)) u_rr (
        .cand     (cand),
        .last_idx (last_idx),
        .pick_idx (pick_idx),
        .pick_ok  (pick_ok)
    );

    grant_keeper #(.NUM_PORTS(NUM_PORTS)) u_keep (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .sel       (sel),
        .locked    (locked),
        .lock_idx  (lock_idx),
        .last_idx  (last_idx)
    );

    // A held grant overrides a fresh pick.
    always_comb sel = locked ? lock_idx : pick_idx;

    // Offer the selected port downstream.
    always_comb out_valid = locked ? req_valid[sel] : (any_valid && pick_ok);

    // Forward the selected port's payload unchanged.
    always_comb begin
        out_addr = req_addr[sel*ADDR_W +: ADDR_W];
        out_id   = req_id[sel*ID_W +: ID_W];
        out_qos  = req_qos[sel*QOS_W +: QOS_W];
        out_port = sel;
    end

    // Accept only the granted port, only when downstream takes it.
    always_comb begin
        req_ready = '0;
        if (out_valid && out_ready)
            req_ready[sel] = 1'b1;
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R6
    AST_READY_NEEDS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |-> (out_ready && out_valid)); // R6
    AST_HOLD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_addr))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid) |-> !out_valid); // R8

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_prio_chk
        AST_NO_HIGHER_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !locked && req_valid[g]) |-> (req_qos[g*QOS_W +: QOS_W] <= out_qos)); // R2
    end
endmodule

// File: tb/qos_addr_arbiter_test.sv
module qos_addr_arbiter_test;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int IW = 4;
    localparam int QW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req_valid;
    logic [N-1:0]    req_ready;
    logic [N*AW-1:0] req_addr;
    logic [N*IW-1:0] req_id;
    logic [N*QW-1:0] req_qos;
    logic            out_valid;
    logic            out_ready;
    logic [AW-1:0]   out_addr;
    logic [IW-1:0]   out_id;
    logic [QW-1:0]   out_qos;
    logic [1:0]      out_port;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    qos_addr_arbiter #(.NUM_PORTS(N), .ADDR_W(AW), .ID_W(IW), .QOS_W(QW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_id(req_id), .req_qos(req_qos),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_id(out_id), .out_qos(out_qos), .out_port(out_port)
    );

    typedef struct packed {
        logic [3:0]  v;
        logic [15:0] q;
        logic        r;
        logic        ov;
        logic [1:0]  p;
    } vec_t;

    // Back-to-back stimulus; rotation pointer starts at port 3 after reset.
    localparam vec_t VECS [13] = '{
        '{4'b0000, 16'h0000, 1'b1, 1'b0, 2'd0},
        '{4'b1111, 16'h0000, 1'b1, 1'b1, 2'd0},
        '{4'b1111, 16'h0000, 1'b1, 1'b1, 2'd1},
        '{4'b1111, 16'h0500, 1'b1, 1'b1, 2'd2},
        '{4'b1111, 16'h5005, 1'b1, 1'b1, 2'd3},
        '{4'b1111, 16'h5005, 1'b1, 1'b1, 2'd0},
        '{4'b0110, 16'h0FF0, 1'b1, 1'b1, 2'd1},
        '{4'b0110, 16'h0FF0, 1'b1, 1'b1, 2'd2},
        '{4'b1001, 16'h1000, 1'b1, 1'b1, 2'd3},
        '{4'b0001, 16'h0000, 1'b1, 1'b1, 2'd0},
        '{4'b1100, 16'h7700, 1'b0, 1'b1, 2'd2},
        '{4'b1100, 16'h7700, 1'b1, 1'b1, 2'd2},
        '{4'b1100, 16'h7700, 1'b1, 1'b1, 2'd3}
    };

    function automatic logic [AW-1:0] addr_of(int i);
        return 32'h4000_0100 * (i + 1) + 32'h3;
    endfunction

    function automatic logic [IW-1:0] id_of(int i);
        return IW'(i * 3 + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [15:0] q, input logic r);
        @(negedge clk);
        req_valid = v;
        req_qos   = q;
        out_ready = r;
        #1;
    endtask

    task automatic check_grant(input logic ov, input logic [1:0] p, input logic r, input string tag);
        logic [3:0] exp_rdy;
        exp_rdy = (ov && r) ? (4'b1 << p) : 4'b0;
        chk(out_valid == ov, {tag, " out_valid"}, 32'(out_valid), 32'(ov));
        chk(req_ready == exp_rdy, "R6 req_ready", 32'(req_ready), 32'(exp_rdy));
        if (ov) begin
            chk(out_port == p, {tag, " out_port"}, 32'(out_port), 32'(p));
            chk(out_addr == addr_of(int'(p)), "R7 out_addr", out_addr, addr_of(int'(p)));
            chk(out_id == id_of(int'(p)), "R7 out_id", 32'(out_id), 32'(id_of(int'(p))));
            chk(out_qos == req_qos[p*QW +: QW], "R7 out_qos", 32'(out_qos), 32'(req_qos[p*QW +: QW]));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = '0;
        req_qos   = '0;
        out_ready = 1'b0;
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW] = addr_of(i);
            req_id[i*IW +: IW]   = id_of(i);
        end
        do_reset();

        // R8 / R1: idle after reset
        #1;
        chk(out_valid == 1'b0, "R8 idle out_valid", 32'(out_valid), 32'h0);
        chk(req_ready == 4'b0, "R1 reset req_ready", 32'(req_ready), 32'h0);

        // Table walk: R1 first pick, R2 priority, R4 rotation and wrap, R5 lock, R7 payload, R8 idle
        for (int k = 0; k < 13; k++) begin
            drive(VECS[k].v, VECS[k].q, VECS[k].r);
            check_grant(VECS[k].ov, VECS[k].p, VECS[k].r, (k == 1) ? "R1" : ((k == 3) ? "R2" : "R4"));
        end

        // R3: QoS 0 at the next port in rotation loses to QoS 1 (last is 3, so port 0 would be next)
        drive(4'b0000, 16'h0000, 1'b1);
        drive(4'b0101, 16'h0100, 1'b0);
        chk(out_port == 2'd2, "R3 zero qos loses", 32'(out_port), 32'd2);
        drive(4'b0101, 16'h0100, 1'b1);
        chk(out_port == 2'd2, "R3 zero qos loses", 32'(out_port), 32'd2);
        drive(4'b0001, 16'h0000, 1'b1);
        chk(out_valid && out_port == 2'd0, "R3 zero qos alone wins", 32'(out_port), 32'd0);

        // R5: stalled low-QoS grant challenged by higher QoS (last is now 0)
        drive(4'b0010, 16'h0020, 1'b0);
        chk(out_port == 2'd1, "R5 initial grant", 32'(out_port), 32'd1);
        drive(4'b1010, 16'hF020, 1'b0);
        chk(out_port == 2'd1, "R5 hold port", 32'(out_port), 32'd1);
        chk(out_addr == addr_of(1), "R5 hold addr", out_addr, addr_of(1));
        chk(req_ready == 4'b0, "R6 no ready while stalled", 32'(req_ready), 32'h0);
        drive(4'b1010, 16'hF020, 1'b1);
        chk(out_port == 2'd1 && req_ready == 4'b0010, "R5 release on handshake", 32'(req_ready), 32'h2);
        drive(4'b1000, 16'hF000, 1'b1);
        chk(out_port == 2'd3, "R2 challenger next", 32'(out_port), 32'd3);

        // R9: reset while locked, then equal QoS from all ports picks port 0
        drive(4'b0100, 16'h0300, 1'b0);
        chk(out_port == 2'd2, "R9 lock before reset", 32'(out_port), 32'd2);
        do_reset();
        drive(4'b1111, 16'h2222, 1'b0);
        chk(out_valid && out_port == 2'd0, "R9 state cleared", 32'(out_port), 32'd0);

        drive(4'b0000, 16'h0000, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule